// File: doc/BRIEF.md
# Processor Exception Classifier

This unit sits next to the decode and execute stages of a small 32-bit processor. Each cycle it looks at the attributes of the instruction being issued. Those attributes are: whether the decoder recognised the opcode, the top opcode nibble, the addressing-mode flags, bit 0 of any jump or branch target, whether the instruction needs supervisor mode, the divisor operand, whether a memory store hits a write-protected region, and whether tracing is on. From these it selects at most one exception.

In the same cycle that the cause is present, the unit raises a combinational `flush_req` so the pipeline can cancel younger work. On the next clock edge it presents a single-cycle `exc_vld` pulse. The pulse carries the registered vector number and the byte offset of that vector in the vector table, which is four times the vector number. Stack frame construction, memory access and opcode decoding are outside this unit; the decoder's verdicts arrive as input flags.

Top module: `exc_vectorizer`

## Requirements
- R1: A store (`mem_store`=1) to write-protected memory (`wr_prot`=1) selects vector 2. When `wr_prot`=1 but `mem_store`=0, as for a fetch or an operand read, no access exception is produced.
- R2: A control transfer (`is_xfer`=1) whose target has bit 0 set (`tgt_lsb`=1) selects vector 3. An even target produces no exception.
- R3: An indexed mode (`ea_indexed`=1) selects vector 3 when the index register is word sized (`idx_word`=1) or when the scale code `idx_scale` is 2'b11 (scale 8). Scale codes 2'b00 to 2'b10 with a long index produce no exception.
- R4: A full-format indexed mode (`ea_full_idx`=1) selects vector 3.
- R5: An unrecognised opcode (`opc_known`=0) selects vector 10 when opcode bits [15:12] are 4'hA, vector 11 when they are 4'hF, and vector 4 otherwise. A recognised opcode never selects an illegal-opcode vector.
- R6: A supervisor-only instruction (`priv_insn`=1) issued in user mode (`sup_mode`=0) selects vector 8. The same instruction in supervisor mode produces no exception.
- R7: A divide or remainder instruction (`is_div`=1) with an all-zero `div_den` selects vector 5, which is offset 0x014. A nonzero divisor produces no exception.
- R8: With tracing on (`trace_on`=1), a completing instruction that has no other exception selects vector 9.
- R9: When several causes occur together, the winner is chosen in this order, highest first: access, address, illegal opcode, privilege, divide-by-zero, trace.
- R10: `exc_off` equals `exc_vec` multiplied by 4.
- R11: `flush_req` is high in the same cycle as any selected cause. `exc_vld`, `exc_vec` and `exc_off` present that cause one cycle later for one cycle, and read 0 in any cycle after a cycle with no cause. Nothing is selected when `issue_vld`=0.
- R12: A synchronous reset (`rst`=1) clears `exc_vld`, `exc_vec` and `exc_off` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | An instruction is being classified this cycle |
| opcode | input | 16 | First opcode word |
| opc_known | input | 1 | Decoder recognised the full opcode word |
| is_xfer | input | 1 | Instruction transfers control |
| tgt_lsb | input | 1 | Bit 0 of the transfer target |
| ea_indexed | input | 1 | Brief indexed addressing mode in use |
| idx_word | input | 1 | Index register is word sized |
| idx_scale | input | 2 | Index scale code (2'b11 is scale 8) |
| ea_full_idx | input | 1 | Full-format indexed mode in use |
| is_div | input | 1 | Divide or remainder instruction |
| div_den | input | DATA_W | Divisor operand |
| priv_insn | input | 1 | Instruction needs supervisor mode |
| sup_mode | input | 1 | 1 means supervisor, 0 means user |
| mem_store | input | 1 | Access is a store |
| wr_prot | input | 1 | Target region is write protected |
| trace_on | input | 1 | Trace mode is active |
| flush_req | output | 1 | Combinational pipeline flush request |
| exc_vld | output | 1 | Registered exception pulse |
| exc_vec | output | 8 | Registered vector number |
| exc_off | output | 10 | Registered vector table byte offset |

## Verification
The assertions assume that every input is stable between clock edges and that the opcode flags describe one instruction per cycle. They also assume that reset is held for at least one edge before the first cycle that is checked, so that every `$past` value comes from a classified cycle.

The bench drives inputs only at the falling edge. Its random phase sets each cause flag with low probability and forces a zero divisor or an 0xA or 0xF opcode nibble often enough to reach every vector and every priority collision. Directed cases cover the boundaries.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W  = 8;
  localparam int OFF_W  = VEC_W + 2;
  localparam int NCAUSE = 6;

  // Index 0 wins; order is the resolution priority.
  typedef enum logic [2:0] {
    C_ACC = 3'd0,
    C_ADR = 3'd1,
    C_ILL = 3'd2,
    C_PRV = 3'd3,
    C_DIV = 3'd4,
    C_TRC = 3'd5
  } cause_e;

  localparam logic [VEC_W-1:0] V_ACC   = 8'd2;
  localparam logic [VEC_W-1:0] V_ADR   = 8'd3;
  localparam logic [VEC_W-1:0] V_ILL   = 8'd4;
  localparam logic [VEC_W-1:0] V_DIV   = 8'd5;
  localparam logic [VEC_W-1:0] V_PRV   = 8'd8;
  localparam logic [VEC_W-1:0] V_TRC   = 8'd9;
  localparam logic [VEC_W-1:0] V_LINEA = 8'd10;
  localparam logic [VEC_W-1:0] V_LINEF = 8'd11;

  function automatic logic [OFF_W-1:0] vec_offset(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  function automatic logic [VEC_W-1:0] illegal_vec(input logic [3:0] line);
    if (line == 4'hA)      return V_LINEA;
    else if (line == 4'hF) return V_LINEF;
    else                   return V_ILL;
  endfunction

  function automatic logic [VEC_W-1:0] cause_vec(input int idx,
                                                 input logic [VEC_W-1:0] ill_v);
    case (idx)
      0:       return V_ACC;
      1:       return V_ADR;
      2:       return ill_v;
      3:       return V_PRV;
      4:       return V_DIV;
      default: return V_TRC;
    endcase
  endfunction
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 issue_vld,
  input  logic [15:0]          opcode,
  input  logic                 opc_known,
  input  logic                 is_xfer,
  input  logic                 tgt_lsb,
  input  logic                 ea_indexed,
  input  logic                 idx_word,
  input  logic [1:0]           idx_scale,
  input  logic                 ea_full_idx,
  input  logic                 is_div,
  input  logic [DATA_W-1:0]    div_den,
  input  logic                 priv_insn,
  input  logic                 sup_mode,
  input  logic                 mem_store,
  input  logic                 wr_prot,
  input  logic                 trace_on,
  output logic [NCAUSE-1:0]    raw,
  output logic [VEC_W-1:0]     ill_vec
);
  localparam logic [1:0] SCALE8 = 2'b11;

  logic acc_hit, adr_odd, adr_idx, adr_full, ill_hit, prv_hit, div_hit, trc_hit;

  // Only stores can fault on protection; reads and fetches never do.
  assign acc_hit  = issue_vld & mem_store & wr_prot;
  assign adr_odd  = issue_vld & is_xfer & tgt_lsb;
  assign adr_idx  = issue_vld & ea_indexed & (idx_word | (idx_scale == SCALE8));
  assign adr_full = issue_vld & ea_full_idx;
  assign ill_hit  = issue_vld & ~opc_known;
  assign prv_hit  = issue_vld & priv_insn & ~sup_mode;
  assign div_hit  = issue_vld & is_div & (div_den == '0);
  assign trc_hit  = issue_vld & trace_on;

  assign ill_vec = illegal_vec(opcode[15:12]);

  always_comb begin
    raw        = '0;
    raw[C_ACC] = acc_hit;
    raw[C_ADR] = adr_odd | adr_idx | adr_full;
    raw[C_ILL] = ill_hit;
    raw[C_PRV] = prv_hit;
    raw[C_DIV] = div_hit;
    raw[C_TRC] = trc_hit;
  end

  logic [11:0] unused_op;
  assign unused_op = opcode[11:0];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  assign any = |req;

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  // R9
  gnt_present_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> ($countones(gnt) == 1));
endmodule

// File: rtl/exc_vec_reg.sv
module exc_vec_reg
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [VEC_W-1:0] vec_d,
  output logic             exc_vld,
  output logic [VEC_W-1:0] exc_vec,
  output logic [OFF_W-1:0] exc_off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_vld <= 1'b0;
      exc_vec <= '0;
      exc_off <= '0;
    end else begin
      exc_vld <= fire;
      exc_vec <= fire ? vec_d : '0;
      exc_off <= fire ? vec_offset(vec_d) : '0;
    end
  end

  // R11
  pulse_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> exc_vld);
  // R11
  quiet_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (!exc_vld && exc_vec == '0));
  // R10
  offset_scale_chk: assert property (@(posedge clk) disable iff (rst)
    exc_off[1:0] == 2'b00 && exc_off[OFF_W-1:2] == exc_vec);
endmodule

// File: rtl/exc_vectorizer.sv
module exc_vectorizer
  import exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_vld,
  input  logic [15:0]       opcode,
  input  logic              opc_known,
  input  logic              is_xfer,
  input  logic              tgt_lsb,
  input  logic              ea_indexed,
  input  logic              idx_word,
  input  logic [1:0]        idx_scale,
  input  logic              ea_full_idx,
  input  logic              is_div,
  input  logic [DATA_W-1:0] div_den,
  input  logic              priv_insn,
  input  logic              sup_mode,
  input  logic              mem_store,
  input  logic              wr_prot,
  input  logic              trace_on,
  output logic              flush_req,
  output logic              exc_vld,
  output logic [7:0]        exc_vec,
  output logic [9:0]        exc_off
);
  logic [NCAUSE-1:0] raw, gnt;
  logic [VEC_W-1:0]  ill_vec, sel_vec;
  logic              any_cause;

  exc_detect #(.DATA_W(DATA_W)) u_det (
    .issue_vld(issue_vld), .opcode(opcode), .opc_known(opc_known),
    .is_xfer(is_xfer), .tgt_lsb(tgt_lsb), .ea_indexed(ea_indexed),
    .idx_word(idx_word), .idx_scale(idx_scale), .ea_full_idx(ea_full_idx),
    .is_div(is_div), .div_den(div_den), .priv_insn(priv_insn),
    .sup_mode(sup_mode), .mem_store(mem_store), .wr_prot(wr_prot),
    .trace_on(trace_on), .raw(raw), .ill_vec(ill_vec)
  );

  exc_arbiter #(.N(NCAUSE)) u_arb (
    .clk(clk), .rst(rst), .req(raw), .gnt(gnt), .any(any_cause)
  );

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NCAUSE; i++)
      if (gnt[i]) sel_vec = sel_vec | cause_vec(i, ill_vec);
  end

  assign flush_req = any_cause;

  exc_vec_reg u_reg (
    .clk(clk), .rst(rst), .fire(any_cause), .vec_d(sel_vec),
    .exc_vld(exc_vld), .exc_vec(exc_vec), .exc_off(exc_off)
  );

  // R1
  acc_store_only_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && exc_vec == 8'd2) |-> $past(mem_store && wr_prot));
  // R2
  adr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && exc_vec == 8'd3) |->
      $past((is_xfer && tgt_lsb) || ea_full_idx ||
            (ea_indexed && (idx_word || idx_scale == 2'b11))));
  // R6
  prv_user_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && exc_vec == 8'd8) |-> $past(priv_insn && !sup_mode));
  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && exc_vec == 8'd5) |-> $past(is_div && div_den == '0));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> !exc_vld);
endmodule

// File: tb/tb_exc_vectorizer.sv
module tb_exc_vectorizer;
  localparam int DATA_W = 32;

  logic clk = 1'b0, rst;
  logic issue_vld, opc_known, is_xfer, tgt_lsb, ea_indexed, idx_word;
  logic ea_full_idx, is_div, priv_insn, sup_mode, mem_store, wr_prot, trace_on;
  logic [15:0] opcode;
  logic [1:0]  idx_scale;
  logic [DATA_W-1:0] div_den;
  logic flush_req, exc_vld;
  logic [7:0] exc_vec;
  logic [9:0] exc_off;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  exc_vectorizer #(.DATA_W(DATA_W)) dut (.*);

  function automatic int expect_vec();
    if (!issue_vld) return 0;
    if (mem_store && wr_prot) return 2;
    if ((is_xfer && tgt_lsb) || ea_full_idx ||
        (ea_indexed && (idx_word || idx_scale == 2'b11))) return 3;
    if (!opc_known) begin
      case (opcode[15:12])
        4'hA: return 10;
        4'hF: return 11;
        default: return 4;
      endcase
    end
    if (priv_insn && !sup_mode) return 8;
    if (is_div && div_den == 0) return 5;
    if (trace_on) return 9;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    issue_vld = 0; opcode = 16'h4E71; opc_known = 1; is_xfer = 0; tgt_lsb = 0;
    ea_indexed = 0; idx_word = 0; idx_scale = 2'b00; ea_full_idx = 0;
    is_div = 0; div_den = 32'd7; priv_insn = 0; sup_mode = 1;
    mem_store = 0; wr_prot = 0; trace_on = 0;
  endtask

  // Inputs already set; call right after a falling edge.
  task automatic step(string req);
    int ev;
    ev = expect_vec();
    #1;
    check({req, " flush"}, int'(flush_req), int'(ev != 0));
    @(posedge clk); #1;
    check({req, " vld"}, int'(exc_vld), int'(ev != 0));
    check({req, " vec"}, int'(exc_vec), ev);
    check("R10 off", int'(exc_off), ev * 4);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst = 1;
    issue_vld = 1; mem_store = 1; wr_prot = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R12 vld", int'(exc_vld), 0);
    check("R12 vec", int'(exc_vec), 0);
    check("R12 off", int'(exc_off), 0);
    @(negedge clk); rst = 0; idle();

    issue_vld = 1; mem_store = 1; wr_prot = 1; step("R1 store");
    issue_vld = 1; mem_store = 0; wr_prot = 1; step("R1 read");
    issue_vld = 1; is_xfer = 1; tgt_lsb = 1; step("R2 odd");
    issue_vld = 1; is_xfer = 1; tgt_lsb = 0; step("R2 even");
    issue_vld = 1; ea_indexed = 1; idx_word = 1; step("R3 word");
    issue_vld = 1; ea_indexed = 1; idx_scale = 2'b11; step("R3 scale8");
    issue_vld = 1; ea_indexed = 1; idx_scale = 2'b10; step("R3 scale4");
    issue_vld = 1; ea_full_idx = 1; step("R4 full");
    issue_vld = 1; opc_known = 0; opcode = 16'hA123; step("R5 lineA");
    issue_vld = 1; opc_known = 0; opcode = 16'hF800; step("R5 lineF");
    issue_vld = 1; opc_known = 0; opcode = 16'h4AFC; step("R5 other");
    issue_vld = 1; opcode = 16'hA123; step("R5 known");
    issue_vld = 1; priv_insn = 1; sup_mode = 0; step("R6 user");
    issue_vld = 1; priv_insn = 1; sup_mode = 1; step("R6 super");
    issue_vld = 1; is_div = 1; div_den = 0; step("R7 zero");
    issue_vld = 1; is_div = 1; div_den = 32'h8000_0000; step("R7 nonzero");
    issue_vld = 1; trace_on = 1; step("R8 trace");
    issue_vld = 1; mem_store = 1; wr_prot = 1; ea_full_idx = 1; opc_known = 0;
    priv_insn = 1; sup_mode = 0; is_div = 1; div_den = 0; trace_on = 1;
    step("R9 all");
    issue_vld = 1; opc_known = 0; opcode = 16'hF000; priv_insn = 1; sup_mode = 0;
    step("R9 ill_prv");
    issue_vld = 1; priv_insn = 1; sup_mode = 0; is_div = 1; div_den = 0;
    trace_on = 1; step("R9 prv_div");
    issue_vld = 0; mem_store = 1; wr_prot = 1; trace_on = 1; step("R11 idle");

    // back-to-back exceptions, then a quiet cycle
    issue_vld = 1; is_div = 1; div_den = 0;
    #1; @(posedge clk); #1;
    check("R11 b2b vec", int'(exc_vec), 5);
    @(negedge clk); idle(); issue_vld = 1; trace_on = 1;
    #1; @(posedge clk); #1;
    check("R11 b2b vec", int'(exc_vec), 9);
    @(negedge clk); idle();
    #1; @(posedge clk); #1;
    check("R11 clear", int'(exc_vec), 0);
    @(negedge clk);

    for (int n = 0; n < 3000; n++) begin
      issue_vld   = ($urandom % 8) != 0;
      mem_store   = ($urandom % 6) == 0;
      wr_prot     = ($urandom % 3) == 0;
      is_xfer     = ($urandom % 4) == 0;
      tgt_lsb     = ($urandom % 3) == 0;
      ea_indexed  = ($urandom % 5) == 0;
      idx_word    = ($urandom % 3) == 0;
      idx_scale   = 2'($urandom);
      ea_full_idx = ($urandom % 12) == 0;
      opc_known   = ($urandom % 5) != 0;
      opcode      = 16'($urandom);
      if (($urandom % 3) == 0) opcode[15:12] = ($urandom % 2) ? 4'hA : 4'hF;
      priv_insn   = ($urandom % 5) == 0;
      sup_mode    = ($urandom % 2) == 0;
      is_div      = ($urandom % 4) == 0;
      div_den     = ($urandom % 3) == 0 ? 32'd0 : $urandom;
      trace_on    = ($urandom % 4) == 0;
      step("R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule